// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt sources into one vectored request for a processor core. The sources are two active-low external pins, overflow events from three timers and a request from a serial port. Software sets a global enable and one enable per source, and gives each source a high or low priority bit. The block presents one request with a 3-bit source index. It takes an acknowledge when the core vectors, and it takes a return pulse when the handler finishes.

Each external pin can trigger on a low level or on a falling edge. The edge latches in a flag, and the flag clears itself when the core vectors to that pin's handler. The flags for timers 0 and 1 also clear themselves on vectoring. The serial and timer-2 requests are level inputs that software clears elsewhere. The block tracks one in-service bit per priority level. A high-priority request can interrupt a low-priority handler, but no request can interrupt a high-priority handler.

Top module: `irq_vector_ctl`

## Requirements
- R1: The enable register resets to 0. Bit 7 is the global enable, bit 6 is ignored, and bits 0 to 5 enable the sources in index order: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial, 5 timer 2. A source with its bit at 0 is never requested.
- R2: While enable bit 7 is 0, `irq_req` stays low, whatever bits 0 to 5 hold.
- R3: The priority register resets to 0. Bits 0 to 5 follow the source order of R1, and a 1 gives that source high priority. Bits 6 and 7 are ignored.
- R4: With `ext_trig[k]` = 0, external pin k requests for as long as the synchronized pin is low. Nothing is latched, so an acknowledge does not remove the request.
- R5: With `ext_trig[k]` = 1, a falling edge on pin k (synchronized value 1 and then 0) sets a flag. The flag holds after the pin returns high, and it clears when that source is acknowledged.
- R6: A one-cycle pulse on `tmr_ovf[0]` (timer 0) or `tmr_ovf[1]` (timer 1) sets a flag. The flag clears when that source is acknowledged.
- R7: The inputs `ser_flag` and `tmr2_flag` request for as long as they are high. Acknowledging them does not clear them.
- R8: Among pending sources of the same priority level, the lowest index wins.
- R9: A pending high-priority source wins over any pending low-priority source.
- R10: While a low-priority service is active, only high-priority sources are requested. While a high-priority service is active, no source is requested.
- R11: A `reti` pulse clears the high-level in-service bit if it is set, and otherwise clears the low-level bit.
- R12: `irq_ack` takes effect only while `irq_req` is high. An acknowledge with no request leaves every flag and in-service bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| pri_wr | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 8 | Priority register write data |
| ext_n | input | 2 | External interrupt pins, active low, asynchronous |
| ext_trig | input | 2 | Per pin: 0 selects low level, 1 selects falling edge |
| tmr_ovf | input | 2 | Overflow pulses from timer 0 (bit 0) and timer 1 (bit 1) |
| tmr2_flag | input | 1 | Timer-2 request level |
| ser_flag | input | 1 | Serial-port request level |
| irq_req | output | 1 | Vector request to the core |
| irq_idx | output | 3 | Index of the requested source |
| irq_ack | input | 1 | The core is vectoring to `irq_idx` |
| reti | input | 1 | Pulse at the end of a handler |

## Verification
The assertions assume that `reti` arrives only while a service is active and never in the same cycle as an accepted acknowledge. They also assume that a timer overflow pulse does not coincide with the acknowledge of that same timer. The bench drives each of these controls on its own falling clock edge and keeps them in separate cycles. It issues a return only after an acknowledge it has made itself. The external pins are held for several cycles, so every change passes through the synchronizer before the bench samples the request.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned N_SRC = 6;
   localparam int unsigned IDX_W = 3;

   typedef enum logic [IDX_W-1:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4,
      SRC_TMR2 = 3'd5
   } src_e;

   localparam int unsigned GLOBAL_BIT = 7;
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic req
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_pin_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   flag_q;
   logic                   fall;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[s] <= 1'b1;
               else        sync_q[s] <= pin_n;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[s] <= 1'b1;
               else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   assign fall = prev_q & ~sync_q[LAST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         prev_q <= sync_q[LAST];
         if (!edge_mode)
            flag_q <= 1'b0;
         else
            flag_q <= fall | (flag_q & ~clr);
      end
   end

   assign req = edge_mode ? flag_q : ~sync_q[LAST];

   // R5: a detected fall in edge mode always leaves the flag set
   a_r5_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && fall) |=> flag_q);
   // R5: the flag drops only through an acknowledge-driven clear or a mode change
   a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N     = 6,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   generate
      if ((1 << IDX_W) < N) begin : g_bad_width
         $error("irq_prio_pick: IDX_W too small for N");
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign any = |vec;

   // R8: the chosen index is always one of the pending bits
   always_comb begin
      a_r8_pick_valid: assert (!any || vec[idx]);
   end
endmodule

// File: rtl/irq_service_track.sv
module irq_service_track (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_hi,
   input  logic ret,
   output logic hi_act,
   output logic lo_act
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_act <= 1'b0;
         lo_act <= 1'b0;
      end else begin
         if (ret) begin
            if (hi_act) hi_act <= 1'b0;
            else        lo_act <= 1'b0;
         end
         if (take) begin
            if (take_hi) hi_act <= 1'b1;
            else         lo_act <= 1'b1;
         end
      end
   end

   // R11: a return during high service ends the high level and leaves the low level alone
   a_r11_ret_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && hi_act && !take) |=> (!hi_act && (lo_act == $past(lo_act))));
   // R11: a return with only low service active ends it
   a_r11_ret_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && !hi_act && !take) |=> !lo_act);
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter logic [5:0]  AUTOCLR_MASK = 6'b001111
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_wr,
   input  logic [7:0] en_wdata,
   input  logic       pri_wr,
   input  logic [7:0] pri_wdata,
   input  logic [1:0] ext_n,
   input  logic [1:0] ext_trig,
   input  logic [1:0] tmr_ovf,
   input  logic       tmr2_flag,
   input  logic       ser_flag,
   output logic       irq_req,
   output logic [2:0] irq_idx,
   input  logic       irq_ack,
   input  logic       reti
);
   import irq_pkg::*;

   localparam int unsigned N_EXT = 2;
   localparam int unsigned N_TMR = 2;

   generate
      if (N_SRC != 6 || IDX_W != 3) begin : g_bad_pkg
         $error("irq_vector_ctl: register layout fixed at six sources");
      end
   endgenerate

   logic             glob_en_q;
   logic [N_SRC-1:0] src_en_q;
   logic [N_SRC-1:0] src_hi_q;
   logic [N_SRC-1:0] src_raw;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] clr_vec;
   logic [N_SRC-1:0] hi_vec;
   logic [N_SRC-1:0] lo_vec;
   logic             hi_any, lo_any;
   logic [IDX_W-1:0] hi_idx, lo_idx;
   logic             hi_act, lo_act;
   logic             hi_ok, lo_ok;
   logic             take, take_hi;
   logic             unused_bits;

   assign unused_bits = ^{en_wdata[6], pri_wdata[7:6]};

   // register file: only meaningful bits are kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en_q <= 1'b0;
         src_en_q  <= '0;
         src_hi_q  <= '0;
      end else begin
         if (en_wr) begin
            glob_en_q <= en_wdata[GLOBAL_BIT];
            src_en_q  <= en_wdata[N_SRC-1:0];
         end
         if (pri_wr) src_hi_q <= pri_wdata[N_SRC-1:0];
      end
   end

   // per-source acknowledge decode
   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_clr
         assign clr_vec[i] = take && (irq_idx == IDX_W'(i)) && AUTOCLR_MASK[i];
      end
   endgenerate

   // external pins at indices 0 and 2
   generate
      for (genvar k = 0; k < N_EXT; k++) begin : g_ext
         localparam int unsigned SI = 2 * k;
         irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[k]),
            .edge_mode (ext_trig[k]),
            .clr       (clr_vec[SI]),
            .req       (src_raw[SI])
         );
      end
   endgenerate

   // timer overflow flags at indices 1 and 3
   generate
      for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
         localparam int unsigned SI = 2 * k + 1;
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= tmr_ovf[k] | (flag_q & ~clr_vec[SI]);
         assign src_raw[SI] = flag_q;

         // R6: an overflow pulse always leaves its flag set
         a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf[k] |=> flag_q);
         if (AUTOCLR_MASK[SI]) begin : g_auto
            // R6: acknowledging the timer removes its flag
            a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
               (take && irq_idx == IDX_W'(SI) && !tmr_ovf[k]) |=> !flag_q);
         end
      end
   endgenerate

   assign src_raw[SRC_SER]  = ser_flag;
   assign src_raw[SRC_TMR2] = tmr2_flag;

   // gating and level split
   assign pend   = glob_en_q ? (src_raw & src_en_q) : '0;
   assign hi_vec = pend & src_hi_q;
   assign lo_vec = pend & ~src_hi_q;

   irq_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick_hi (
      .vec (hi_vec),
      .any (hi_any),
      .idx (hi_idx)
   );

   irq_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick_lo (
      .vec (lo_vec),
      .any (lo_any),
      .idx (lo_idx)
   );

   assign hi_ok   = hi_any && !hi_act;
   assign lo_ok   = lo_any && !hi_act && !lo_act;
   assign irq_req = hi_ok || lo_ok;
   assign irq_idx = hi_ok ? hi_idx : lo_idx;
   assign take    = irq_ack && irq_req;
   assign take_hi = hi_ok;

   irq_service_track u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .take_hi (take_hi),
      .ret     (reti),
      .hi_act  (hi_act),
      .lo_act  (lo_act)
   );

   // R2: nothing is forwarded without the global enable
   a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en_q |-> !irq_req);
   // R1: a requested source always has its enable bit set
   a_r1_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> src_en_q[irq_idx]);
   // R10: nothing is requested during high service
   a_r10_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      hi_act |-> !irq_req);
   // R10: during low service only high-priority sources appear
   a_r10_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_act && irq_req) |-> src_hi_q[irq_idx]);
   // R9: a low-priority index is never shown while a high one is pending and allowed
   a_r9_high_first: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && hi_any && !hi_act) |-> src_hi_q[irq_idx]);
   // R12: without a request, an acknowledge leaves service state untouched
   a_r12_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !irq_req && !reti) |=> (hi_act == $past(hi_act) && lo_act == $past(lo_act)));
endmodule

// File: tb/tb_irq_vector_ctl.sv
module tb_irq_vector_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_wr = 1'b0;
   logic [7:0] en_wdata = '0;
   logic       pri_wr = 1'b0;
   logic [7:0] pri_wdata = '0;
   logic [1:0] ext_n = 2'b11;
   logic [1:0] ext_trig = 2'b00;
   logic [1:0] tmr_ovf = 2'b00;
   logic       tmr2_flag = 1'b0;
   logic       ser_flag = 1'b0;
   logic       irq_req;
   logic [2:0] irq_idx;
   logic       irq_ack = 1'b0;
   logic       reti = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   irq_vector_ctl dut (
      .clk(clk), .rst_n(rst_n),
      .en_wr(en_wr), .en_wdata(en_wdata),
      .pri_wr(pri_wr), .pri_wdata(pri_wdata),
      .ext_n(ext_n), .ext_trig(ext_trig),
      .tmr_ovf(tmr_ovf), .tmr2_flag(tmr2_flag), .ser_flag(ser_flag),
      .irq_req(irq_req), .irq_idx(irq_idx),
      .irq_ack(irq_ack), .reti(reti)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_req(input string rq, input logic req_e, input logic [2:0] idx_e);
      checks++;
      if (irq_req !== req_e || (req_e && irq_idx !== idx_e)) begin
         errors++;
         $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d",
                  rq, irq_req, irq_idx, req_e, idx_e);
      end
   endtask

   task automatic set_en(input logic [7:0] v);
      en_wdata = v; en_wr = 1'b1; cyc(1); en_wr = 1'b0;
   endtask

   task automatic set_pri(input logic [7:0] v);
      pri_wdata = v; pri_wr = 1'b1; cyc(1); pri_wr = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
   endtask

   task automatic ret();
      reti = 1'b1; cyc(1); reti = 1'b0;
   endtask

   task automatic t_reset();
      ser_flag = 1'b1; tmr2_flag = 1'b1; cyc(2);
      expect_req("R1 reset enables", 1'b0, 3'd0);
      ser_flag = 1'b0; tmr2_flag = 1'b0;
   endtask

   task automatic t_global();
      set_en(8'h3F); ser_flag = 1'b1; cyc(1);
      expect_req("R2 global off", 1'b0, 3'd0);
      set_en(8'h50); cyc(1);
      expect_req("R1 bit6 not global", 1'b0, 3'd0);
      set_en(8'h90); cyc(1);
      expect_req("R1 serial enabled", 1'b1, 3'd4);
      set_en(8'h80); cyc(1);
      expect_req("R1 serial masked", 1'b0, 3'd0);
      ser_flag = 1'b0; set_en(8'h00);
   endtask

   task automatic t_level();
      ext_trig = 2'b00; set_en(8'h81);
      ext_n[0] = 1'b0; cyc(4);
      expect_req("R4 level request", 1'b1, 3'd0);
      ack(); cyc(1);
      expect_req("R10 blocked in low service", 1'b0, 3'd0);
      ret(); cyc(1);
      expect_req("R4 level not latched off", 1'b1, 3'd0);
      ext_n[0] = 1'b1; cyc(4);
      expect_req("R4 level released", 1'b0, 3'd0);
      set_en(8'h00);
   endtask

   task automatic t_edge();
      ext_trig = 2'b10; set_en(8'h84);
      ext_n[1] = 1'b0; cyc(3); ext_n[1] = 1'b1; cyc(5);
      expect_req("R5 edge latched", 1'b1, 3'd2);
      ack(); ret(); cyc(1);
      expect_req("R5 edge cleared by ack", 1'b0, 3'd0);
      ext_trig = 2'b00; set_en(8'h00);
   endtask

   task automatic t_timers();
      set_en(8'h82);
      tmr_ovf[0] = 1'b1; cyc(1); tmr_ovf[0] = 1'b0; cyc(1);
      expect_req("R6 timer0 flag", 1'b1, 3'd1);
      ack(); ret(); cyc(1);
      expect_req("R6 timer0 cleared", 1'b0, 3'd0);
      set_en(8'h88);
      tmr_ovf[1] = 1'b1; cyc(1); tmr_ovf[1] = 1'b0; cyc(1);
      expect_req("R6 timer1 flag", 1'b1, 3'd3);
      ack(); ret(); cyc(1);
      expect_req("R6 timer1 cleared", 1'b0, 3'd0);
      set_en(8'h00);
   endtask

   task automatic t_sticky();
      set_en(8'hA0); tmr2_flag = 1'b1; cyc(1);
      expect_req("R7 timer2 request", 1'b1, 3'd5);
      ack(); ret(); cyc(1);
      expect_req("R7 timer2 not cleared", 1'b1, 3'd5);
      tmr2_flag = 1'b0; cyc(1);
      expect_req("R7 timer2 dropped", 1'b0, 3'd0);
      set_en(8'h00);
   endtask

   task automatic t_ties();
      set_pri(8'h00); set_en(8'hBF);
      ser_flag = 1'b1; tmr2_flag = 1'b1;
      tmr_ovf[1] = 1'b1; cyc(1); tmr_ovf[1] = 1'b0; cyc(1);
      expect_req("R8 lowest index timer1", 1'b1, 3'd3);
      ack(); ret(); cyc(1);
      expect_req("R8 next serial", 1'b1, 3'd4);
      set_pri(8'hE0); cyc(1);
      expect_req("R9 high timer2 wins", 1'b1, 3'd5);
      set_pri(8'hC0); cyc(1);
      expect_req("R3 bits 7..6 ignored", 1'b1, 3'd4);
      ser_flag = 1'b0; tmr2_flag = 1'b0; set_en(8'h00); set_pri(8'h00);
   endtask

   task automatic t_preempt();
      set_pri(8'h20); set_en(8'hB0);
      ser_flag = 1'b1; cyc(1);
      expect_req("R9 serial alone", 1'b1, 3'd4);
      ack(); tmr2_flag = 1'b1; cyc(1);
      expect_req("R10 high preempts low", 1'b1, 3'd5);
      ack(); cyc(1);
      expect_req("R10 high blocks all", 1'b0, 3'd0);
      tmr2_flag = 1'b0; ret(); cyc(1);
      expect_req("R11 low still active", 1'b0, 3'd0);
      ret(); cyc(1);
      expect_req("R11 low cleared", 1'b1, 3'd4);
      ser_flag = 1'b0; set_en(8'h00); set_pri(8'h00);
   endtask

   task automatic t_stray_ack();
      ack(); cyc(1);
      set_en(8'h90); ser_flag = 1'b1; cyc(1);
      expect_req("R12 stray ack ignored", 1'b1, 3'd4);
      ser_flag = 1'b0; set_en(8'h00);
   endtask

   initial begin
      cyc(3); rst_n = 1'b1; cyc(1);
      t_reset();
      t_global();
      t_level();
      t_edge();
      t_timers();
      t_sticky();
      t_ties();
      t_preempt();
      t_stray_ack();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule